// File: doc/BRIEF.md
# Link-Speed Transmit Rate Throttle

A transmit datapath that moves 64 bits per cycle on a fixed 156.25 MHz clock runs at 10 Gbps. When the attached link is slower, the average frame rate has to come down to match it. This block does that without touching frame contents. It watches the frame generator's busy flag and its idle-gap flag, and measures how many cycles each frame occupied. When the frame ends, it keeps a throttled busy flag asserted for a proportional extra idle period. The frame scheduler uses the throttled flag in place of the raw one, so the next frame cannot start until the stretched gap has elapsed.

A 3-bit speed code selects the slow-down ratio. The code is latched when a frame starts, so a change made in the middle of a frame or during its stretch applies only from the next frame. All counters saturate, so very long frames at the slowest speed never wrap into a short gap.

Top module: `link_rate_throttle`

## Requirements
- R1: While `rst` is high, `busy_out` is low. Synchronous reset clears all internal counting, including a stretch in progress, so after release with idle inputs `busy_out` stays low.
- R2: For speed codes 000, 110 and 111, `busy_out` equals `gen_busy` in every cycle, and no extra gap follows a frame.
- R3: A frame's length N is the number of consecutive cycles in which `gen_busy` or `gen_idle_gap` is high. Gap cycles count toward N.
- R4: In the first cycle after a frame's last active cycle, `busy_out` goes high. It then stays high for exactly (ratio-1)*N consecutive cycles. The ratio is 2, 4, 10, 100 and 1000 for codes 001, 010, 011, 100 and 101.
- R5: During a frame, `busy_out` follows `gen_busy`. A cycle with only `gen_idle_gap` high shows `busy_out` low.
- R6: Both the frame-length count and the stretch length saturate at 2^CNT_W-1 and never wrap.
- R7: The speed code is sampled only in the first cycle of a frame. Changes during the frame or its stretch do not alter that frame's stretch.
- R8: While a stretch is running, pulses on `gen_idle_gap` are ignored: they neither lengthen nor restart the stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst | input | 1 | Synchronous reset, active high |
| speed_code | input | 3 | Link speed selector |
| gen_busy | input | 1 | Raw busy flag from the frame generator |
| gen_idle_gap | input | 1 | Generator is emitting its inter-frame gap |
| busy_out | output | 1 | Throttled busy flag for the frame scheduler |

## Verification
Directed frames at every speed code give stretch lengths that differ by ratio, so a wrong ratio entry or a stretch off by one cycle shows up as a count mismatch. Frames with trailing gap cycles separate counting busy alone from counting busy plus gap. A code change made inside a frame separates latching at the frame start from tracking the live input. A second instance with an 8-bit counter is driven with long frames and high ratios to expose wrapping instead of saturation. Seeded random frames over all eight codes, mixed lengths and gap tails are compared against a bench function of code and length.

// File: rtl/link_rate_throttle.sv
module link_rate_throttle #(
  parameter int CNT_W   = 21,
  parameter int RATIO_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] speed_code,
  input  logic       gen_busy,
  input  logic       gen_idle_gap,
  output logic       busy_out
);
  localparam int PROD_W = CNT_W + RATIO_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {ST_IDLE, ST_COUNT, ST_STRETCH} state_t;

  function automatic logic [RATIO_W-1:0] extra_factor(input logic [2:0] c);
    case (c)
      3'd1:    extra_factor = RATIO_W'(1);
      3'd2:    extra_factor = RATIO_W'(3);
      3'd3:    extra_factor = RATIO_W'(9);
      3'd4:    extra_factor = RATIO_W'(99);
      3'd5:    extra_factor = RATIO_W'(999);
      default: extra_factor = '0;
    endcase
  endfunction

  state_t            state;
  logic [CNT_W-1:0]  frame_cnt, rem;
  logic [2:0]        code_q;
  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0]  extra;
  logic              active, ending;

  assign active = gen_busy | gen_idle_gap;
  assign ending = (state == ST_COUNT) && !active;
  assign prod   = PROD_W'(frame_cnt) * PROD_W'(extra_factor(code_q));
  assign extra  = (|prod[PROD_W-1:CNT_W]) ? CNT_MAX : prod[CNT_W-1:0];

  assign busy_out = !rst && (gen_busy || state == ST_STRETCH || (ending && extra != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      frame_cnt <= '0;
      rem       <= '0;
      code_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (active) begin
          state     <= ST_COUNT;
          frame_cnt <= CNT_W'(1);
          code_q    <= speed_code;
        end
        ST_COUNT: if (active) begin
          if (frame_cnt != CNT_MAX) frame_cnt <= frame_cnt + CNT_W'(1);
        end else begin
          frame_cnt <= '0;
          if (extra > CNT_W'(1)) begin
            rem   <= extra - CNT_W'(1);
            state <= ST_STRETCH;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_STRETCH: if (rem <= CNT_W'(1)) begin
          rem   <= '0;
          state <= ST_IDLE;
        end else begin
          rem <= rem - CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE && frame_cnt == '0 && rem == '0)); // R1
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COUNT && extra_factor(code_q) == '0) |=> state != ST_STRETCH); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COUNT && active && frame_cnt != CNT_MAX) |=>
      frame_cnt == $past(frame_cnt) + CNT_W'(1)); // R3
  AST_STRETCH_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STRETCH && rem > CNT_W'(1)) |=>
      (state == ST_STRETCH && rem == $past(rem) - CNT_W'(1))); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COUNT && active) |=> frame_cnt != '0); // R6
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(code_q)); // R7
  AST_STRETCH_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STRETCH && rem > CNT_W'(1) && gen_idle_gap) |=> rem < $past(rem)); // R8
endmodule

// File: tb/tb_link_rate_throttle.sv
`timescale 1ns/1ps
module tb_link_rate_throttle;
  localparam int SAT_W = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] speed_code = 3'd0;
  logic       gen_busy = 1'b0;
  logic       gen_idle_gap = 1'b0;
  logic       busy_out, busy_out_s;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  link_rate_throttle dut (
    .clk(clk), .rst(rst), .speed_code(speed_code),
    .gen_busy(gen_busy), .gen_idle_gap(gen_idle_gap), .busy_out(busy_out));

  link_rate_throttle #(.CNT_W(SAT_W)) dut_sat (
    .clk(clk), .rst(rst), .speed_code(speed_code),
    .gen_busy(gen_busy), .gen_idle_gap(gen_idle_gap), .busy_out(busy_out_s));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int exp_stretch(input logic [2:0] c, input int n, input int w);
    int m, r, nn;
    longint p;
    m = (1 << w) - 1;
    case (c)
      3'd1: r = 1;
      3'd2: r = 3;
      3'd3: r = 9;
      3'd4: r = 99;
      3'd5: r = 999;
      default: r = 0;
    endcase
    nn = (n > m) ? m : n;
    p = longint'(r) * longint'(nn);
    return (p > longint'(m)) ? m : int'(p);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [2:0] c0, input logic [2:0] c1, input int nb,
                           input int ng, input bit poke, input string req);
    bit bad_b = 0, bad_g = 0;
    int e0, e1, n0 = 0, n1 = 0, win;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      speed_code = (i == 0) ? c0 : c1; gen_busy = 1'b1; gen_idle_gap = 1'b0;
      #1 if (!busy_out || !busy_out_s) bad_b = 1;
    end
    for (int i = 0; i < ng; i++) begin
      @(negedge clk);
      speed_code = c1; gen_busy = 1'b0; gen_idle_gap = 1'b1;
      #1 if (busy_out || busy_out_s) bad_g = 1;
    end
    check(!bad_b, req, "busy_out during busy", bad_b, 0);
    if (ng > 0) check(!bad_g, "R5", "busy_out during gap", bad_g, 0);
    e0 = exp_stretch(c0, nb + ng, 21);
    e1 = exp_stretch(c0, nb + ng, SAT_W);
    win = ((e0 > e1) ? e0 : e1) + 3;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      speed_code = c1; gen_busy = 1'b0;
      gen_idle_gap = poke && e1 > 8 && e0 > 8 && k >= 2 && k < 5;
      #1;
      if (busy_out) n0++;
      if (busy_out_s) n1++;
    end
    gen_idle_gap = 1'b0;
    check(n0 == e0, req, "stretch length", n0, e0);
    check(n1 == e1, req, "stretch length narrow counter", n1, e1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    gen_busy = 1'b1;
    repeat (3) @(negedge clk);
    #1 check(!busy_out && !busy_out_s, "R1", "busy_out in reset", busy_out, 0);
    @(negedge clk); gen_busy = 1'b0; rst = 1'b0;
    repeat (2) @(negedge clk);
    #1 check(!busy_out, "R1", "busy_out after reset", busy_out, 0);

    run_frame(3'd0, 3'd0, 8, 2, 0, "R2");
    run_frame(3'd6, 3'd6, 5, 1, 0, "R2");
    run_frame(3'd7, 3'd7, 9, 0, 0, "R2");
    run_frame(3'd1, 3'd1, 10, 3, 0, "R3");
    run_frame(3'd2, 3'd2, 7, 1, 0, "R4");
    run_frame(3'd3, 3'd3, 12, 0, 0, "R4");
    run_frame(3'd4, 3'd4, 6, 2, 0, "R4");
    run_frame(3'd5, 3'd5, 3, 1, 0, "R4");
    run_frame(3'd2, 3'd5, 6, 2, 0, "R7");
    run_frame(3'd3, 3'd0, 4, 0, 0, "R7");
    run_frame(3'd4, 3'd4, 10, 0, 1, "R8");
    run_frame(3'd3, 3'd3, 20, 0, 1, "R8");
    run_frame(3'd1, 3'd1, 300, 0, 0, "R6");
    run_frame(3'd5, 3'd5, 20, 0, 0, "R6");

    for (int i = 0; i < 4; i++) begin
      @(negedge clk); speed_code = 3'd3; gen_busy = 1'b1;
    end
    @(negedge clk); gen_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    #1 check(!busy_out && !busy_out_s, "R1", "reset during stretch", busy_out, 0);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    #1 check(!busy_out && !busy_out_s, "R1", "idle after reset in stretch", busy_out, 0);

    for (int i = 0; i < 24; i++) begin
      logic [2:0] c;
      int nb, ng;
      c = 3'($urandom_range(0, 7));
      nb = (c == 3'd5) ? 1 + $urandom_range(0, 4) :
           (c == 3'd4) ? 1 + $urandom_range(0, 39) : 1 + $urandom_range(0, 199);
      ng = $urandom_range(0, 3);
      run_frame(c, c, nb, ng, 0, "R4");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule